// File: doc/BRIEF.md
# Stereo Audio Sample FIFO Controller

A bus-slave peripheral that buffers audio samples between a processor and a codec sample interface. It holds four 32-bit sample queues. Two capture queues, left and right, are filled from the codec side. Two playback queues, left and right, are drained toward the codec side. The processor sees four word registers on a small byte-addressed bus: control/status, a packed occupancy word, left data and right data. Reading a data register takes the oldest captured sample for that channel. Writing a data register queues a playback sample for that channel.

The codec side is modelled as strobes. `cap_strobe_i` delivers one stereo capture pair. `play_strobe_i` accepts one stereo playback pair, and only when both playback queues hold a sample. A level-sensitive interrupt asks the processor for attention when captured samples reach three quarters of a queue, or when three quarters of a playback queue stands empty. There is no acknowledge. The line falls only when software moves the queue levels back across the threshold.

Top module: `audio_fifo_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000_0200, the occupancy register reads 0x8080_0000, and `irq_o` and `play_valid_o` are low.
- R2: Each `cap_strobe_i` pushes `cap_left_i` into the left capture queue and `cap_right_i` into the right capture queue. Occupancy bits 15:8 give the left capture count and bits 7:0 give the right capture count.
- R3: A read at byte offset 8 (left) or 12 (right) pops that channel's capture queue in arrival order. The sample appears on `bus_rdata_o` in the cycle after the read strobe and is held until the next read.
- R4: A read of an empty capture queue returns zero and leaves every count unchanged.
- R5: A write at offset 8 or 12 pushes `bus_wdata_i` into the left or right playback queue. Occupancy bits 31:24 give the left playback free space and bits 23:16 give the right playback free space.
- R6: `play_valid_o` is high only when both playback queues are non-empty, and `play_left_o`/`play_right_o` then show the oldest pair. A `play_strobe_i` pops both queues only when `play_valid_o` is high, and has no effect otherwise.
- R7: A push into a full queue (128 entries) is dropped, and the occupancy field saturates at 128.
- R8: Control register (offset 0): bit 0 is the read-interrupt enable and bit 1 is the write-interrupt enable, both read/write. Writing 1 to bit 2 empties both capture queues and writing 1 to bit 3 empties both playback queues. Bits 2 and 3 always read 0.
- R9: Control bit 8 reads 1 when either capture queue holds 96 or more samples. Bit 9 reads 1 when either playback queue has 96 or more free entries. Both bits are read-only and are shown whatever the enables are.
- R10: `irq_o` equals (bit 0 AND bit 8) OR (bit 1 AND bit 9). It stays high with no acknowledge until the queue levels cross back over the threshold or the enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 4 | Byte offset; bits 3:2 select the register |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| cap_strobe_i | input | 1 | Capture pair valid |
| cap_left_i | input | 32 | Left capture sample |
| cap_right_i | input | 32 | Right capture sample |
| play_strobe_i | input | 1 | Codec takes a playback pair |
| play_valid_o | output | 1 | Both playback queues non-empty |
| play_left_o | output | 32 | Oldest left playback sample |
| play_right_o | output | 32 | Oldest right playback sample |
| irq_o | output | 1 | Level interrupt |

## Verification
Read data is registered, so it is due one cycle after the read strobe. Queue counts, the pending bits, `irq_o` and `play_valid_o` follow the clock edge that performs the push, pop or clear. The bench drives every input on the falling edge, lets one rising edge pass, and samples on the next falling edge. Each result is therefore checked in the first cycle it is due and never straddles an edge. Counts are always observed through an occupancy-register read, so they are seen exactly as software would see them.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_SPACE = 2'd1,
    REG_LEFT  = 2'd2,
    REG_RIGHT = 2'd3
  } reg_sel_e;

  localparam int unsigned CTL_RD_EN   = 0;
  localparam int unsigned CTL_WR_EN   = 1;
  localparam int unsigned CTL_CLR_CAP = 2;
  localparam int unsigned CTL_CLR_PLY = 3;
  localparam int unsigned CTL_RD_PND  = 8;
  localparam int unsigned CTL_WR_PND  = 9;

  localparam int unsigned FLD_W = 8;

  // queue slots
  localparam int unsigned Q_CAP_L = 0;
  localparam int unsigned Q_CAP_R = 1;
  localparam int unsigned Q_PLY_L = 2;
  localparam int unsigned Q_PLY_R = 3;
  localparam int unsigned NUM_Q   = 4;
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));
  // R7
  full_push_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !clr_i) |=> $stable(count_o));
  // R4
  empty_pop_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i && !clr_i) |=> empty_o);
  // R8
  clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);
endmodule

// File: rtl/audio_irq_gen.sv
module audio_irq_gen #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cap_l_cnt_i,
  input  logic [CNT_W-1:0] cap_r_cnt_i,
  input  logic [CNT_W-1:0] ply_l_free_i,
  input  logic [CNT_W-1:0] ply_r_free_i,
  input  logic             rd_en_i,
  input  logic             wr_en_i,
  output logic             rd_pend_o,
  output logic             wr_pend_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] THRESH = CNT_W'((DEPTH * 3) / 4);

  assign rd_pend_o = (cap_l_cnt_i >= THRESH) || (cap_r_cnt_i >= THRESH);
  assign wr_pend_o = (ply_l_free_i >= THRESH) || (ply_r_free_i >= THRESH);
  assign irq_o     = (rd_en_i && rd_pend_o) || (wr_en_i && wr_pend_o);

  // R10
  irq_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rd_en_i || wr_en_i));
  // R9
  rd_pend_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_l_cnt_i < THRESH && cap_r_cnt_i < THRESH) |-> !rd_pend_o);
endmodule

// File: rtl/audio_fifo_ctrl.sv
module audio_fifo_ctrl
  import audio_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              cap_strobe_i,
  input  logic [DATA_W-1:0] cap_left_i,
  input  logic [DATA_W-1:0] cap_right_i,
  input  logic              play_strobe_i,
  output logic              play_valid_o,
  output logic [DATA_W-1:0] play_left_o,
  output logic [DATA_W-1:0] play_right_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  reg_sel_e          sel;
  logic              wr_ctrl, clr_cap, clr_ply;
  logic              rd_en_q, wr_en_q, rd_pend, wr_pend;
  logic [NUM_Q-1:0]  q_push, q_pop, q_clr, q_empty, q_full;
  logic [DATA_W-1:0] q_wdata [NUM_Q];
  logic [DATA_W-1:0] q_head  [NUM_Q];
  logic [CNT_W-1:0]  q_cnt   [NUM_Q];
  logic [CNT_W-1:0]  ply_l_free, ply_r_free;
  logic [31:0]       rdata_d, rdata_q;

  function automatic logic [FLD_W-1:0] fld(input logic [CNT_W-1:0] v);
    return FLD_W'(v);
  endfunction

  function automatic logic [31:0] widen(input logic [DATA_W-1:0] v);
    return 32'(v);
  endfunction

  assign sel     = reg_sel_e'(bus_addr_i[3:2]);
  assign wr_ctrl = bus_wr_i && (sel == REG_CTRL);
  assign clr_cap = wr_ctrl && bus_wdata_i[CTL_CLR_CAP];
  assign clr_ply = wr_ctrl && bus_wdata_i[CTL_CLR_PLY];

  assign play_valid_o = !q_empty[Q_PLY_L] && !q_empty[Q_PLY_R];
  assign play_left_o  = q_head[Q_PLY_L];
  assign play_right_o = q_head[Q_PLY_R];

  always_comb begin
    q_push = '0;
    q_pop  = '0;
    q_clr  = '0;
    q_push[Q_CAP_L] = cap_strobe_i;
    q_push[Q_CAP_R] = cap_strobe_i;
    q_push[Q_PLY_L] = bus_wr_i && (sel == REG_LEFT);
    q_push[Q_PLY_R] = bus_wr_i && (sel == REG_RIGHT);
    q_pop[Q_CAP_L]  = bus_rd_i && (sel == REG_LEFT);
    q_pop[Q_CAP_R]  = bus_rd_i && (sel == REG_RIGHT);
    q_pop[Q_PLY_L]  = play_strobe_i && play_valid_o;
    q_pop[Q_PLY_R]  = play_strobe_i && play_valid_o;
    q_clr[Q_CAP_L]  = clr_cap;
    q_clr[Q_CAP_R]  = clr_cap;
    q_clr[Q_PLY_L]  = clr_ply;
    q_clr[Q_PLY_R]  = clr_ply;
  end

  assign q_wdata[Q_CAP_L] = cap_left_i;
  assign q_wdata[Q_CAP_R] = cap_right_i;
  assign q_wdata[Q_PLY_L] = DATA_W'(bus_wdata_i);
  assign q_wdata[Q_PLY_R] = DATA_W'(bus_wdata_i);

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    sample_fifo #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .CNT_W  (CNT_W)
    ) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (q_clr[g]),
      .push_i  (q_push[g]),
      .wdata_i (q_wdata[g]),
      .pop_i   (q_pop[g]),
      .head_o  (q_head[g]),
      .count_o (q_cnt[g]),
      .empty_o (q_empty[g]),
      .full_o  (q_full[g])
    );
  end

  assign ply_l_free = CNT_W'(DEPTH) - q_cnt[Q_PLY_L];
  assign ply_r_free = CNT_W'(DEPTH) - q_cnt[Q_PLY_R];

  audio_irq_gen #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
  ) u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cap_l_cnt_i  (q_cnt[Q_CAP_L]),
    .cap_r_cnt_i  (q_cnt[Q_CAP_R]),
    .ply_l_free_i (ply_l_free),
    .ply_r_free_i (ply_r_free),
    .rd_en_i      (rd_en_q),
    .wr_en_i      (wr_en_q),
    .rd_pend_o    (rd_pend),
    .wr_pend_o    (wr_pend),
    .irq_o        (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_en_q <= 1'b0;
      wr_en_q <= 1'b0;
    end else if (wr_ctrl) begin
      rd_en_q <= bus_wdata_i[CTL_RD_EN];
      wr_en_q <= bus_wdata_i[CTL_WR_EN];
    end
  end

  always_comb begin
    rdata_d = '0;
    unique case (sel)
      REG_CTRL: begin
        rdata_d[CTL_RD_EN]  = rd_en_q;
        rdata_d[CTL_WR_EN]  = wr_en_q;
        rdata_d[CTL_RD_PND] = rd_pend;
        rdata_d[CTL_WR_PND] = wr_pend;
      end
      REG_SPACE: rdata_d = {fld(ply_l_free), fld(ply_r_free),
                            fld(q_cnt[Q_CAP_L]), fld(q_cnt[Q_CAP_R])};
      REG_LEFT:  rdata_d = q_empty[Q_CAP_L] ? '0 : widen(q_head[Q_CAP_L]);
      REG_RIGHT: rdata_d = q_empty[Q_CAP_R] ? '0 : widen(q_head[Q_CAP_R]);
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rdata_d;
  end

  assign bus_rdata_o = rdata_q;

  // R6
  play_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (play_strobe_i && !play_valid_o && !bus_wr_i && !wr_ctrl)
      |=> ($stable(q_cnt[Q_PLY_L]) && $stable(q_cnt[Q_PLY_R])));
  // R6
  play_pair_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (play_strobe_i && play_valid_o && !bus_wr_i && !wr_ctrl)
      |=> (q_cnt[Q_PLY_L] == $past(q_cnt[Q_PLY_L]) - 1'b1));
  // R3
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> $stable(bus_rdata_o));
endmodule

// File: tb/tb_audio_fifo_ctrl.sv
module tb_audio_fifo_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  bus_addr_i = '0;
  logic        bus_rd_i = 1'b0, bus_wr_i = 1'b0;
  logic [31:0] bus_wdata_i = '0, bus_rdata_o;
  logic        cap_strobe_i = 1'b0;
  logic [31:0] cap_left_i = '0, cap_right_i = '0;
  logic        play_strobe_i = 1'b0;
  logic        play_valid_o, irq_o;
  logic [31:0] play_left_o, play_right_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  audio_fifo_ctrl dut (
    .clk_i, .rst_ni, .bus_addr_i, .bus_rd_i, .bus_wr_i, .bus_wdata_i,
    .bus_rdata_o, .cap_strobe_i, .cap_left_i, .cap_right_i,
    .play_strobe_i, .play_valid_o, .play_left_o, .play_right_o, .irq_o
  );

  // op: 0 read, 1 write, 2 capture strobe, 3 playback strobe
  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [31:0] d0;
    logic [31:0] d1;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'h0, 32'h0,    32'h0,  32'h0000_0200, 8'd1},  // R1 ctrl
    '{2'd0, 4'h4, 32'h0,    32'h0,  32'h8080_0000, 8'd1},  // R1 space
    '{2'd2, 4'h0, 32'h11,   32'h22, 32'h0,         8'd2},
    '{2'd2, 4'h0, 32'h33,   32'h44, 32'h0,         8'd2},
    '{2'd0, 4'h4, 32'h0,    32'h0,  32'h8080_0202, 8'd2},  // R2
    '{2'd0, 4'h8, 32'h0,    32'h0,  32'h0000_0011, 8'd3},  // R3
    '{2'd0, 4'hC, 32'h0,    32'h0,  32'h0000_0022, 8'd3},
    '{2'd0, 4'h8, 32'h0,    32'h0,  32'h0000_0033, 8'd3},
    '{2'd0, 4'h8, 32'h0,    32'h0,  32'h0000_0000, 8'd4},  // R4 empty
    '{2'd0, 4'h4, 32'h0,    32'h0,  32'h8080_0001, 8'd4},
    '{2'd1, 4'h8, 32'hAAAA, 32'h0,  32'h0,         8'd5},
    '{2'd0, 4'h4, 32'h0,    32'h0,  32'h7F80_0001, 8'd5},  // R5
    '{2'd3, 4'h0, 32'h0,    32'h0,  32'h0,         8'd6},
    '{2'd0, 4'h4, 32'h0,    32'h0,  32'h7F80_0001, 8'd6},  // R6 no pop
    '{2'd1, 4'hC, 32'hBBBB, 32'h0,  32'h0,         8'd5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr_i = a; bus_rd_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    bus_rd_i = 1'b0;
    d = bus_rdata_o;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic cap(input logic [31:0] l, input logic [31:0] r);
    cap_left_i = l; cap_right_i = r; cap_strobe_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    cap_strobe_i = 1'b0;
  endtask

  task automatic ply();
    play_strobe_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    play_strobe_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 play_valid", {31'b0, play_valid_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        2'd0: begin
          rd(VECS[i].addr, d);
          check($sformatf("R%0d vec%0d", VECS[i].req, i), d, VECS[i].exp);
        end
        2'd1: wr(VECS[i].addr, VECS[i].d0);
        2'd2: cap(VECS[i].d0, VECS[i].d1);
        default: ply();
      endcase
    end

    // R6 pair present and popped together
    check("R6 valid", {31'b0, play_valid_o}, 32'h1);
    check("R6 left", play_left_o, 32'hAAAA);
    check("R6 right", play_right_o, 32'hBBBB);
    ply();
    check("R6 after pop", {31'b0, play_valid_o}, 32'h0);
    rd(4'h4, d); check("R6 space", d, 32'h8080_0001);

    // R8 / R10 enables
    wr(4'h0, 32'h3);
    rd(4'h0, d); check("R8 ctrl rw", d, 32'h0000_0203);
    check("R10 irq write", {31'b0, irq_o}, 32'h1);
    wr(4'h0, 32'h1);
    check("R10 irq off", {31'b0, irq_o}, 32'h0);

    // R9 read threshold: left 95, right 96
    for (int i = 0; i < 95; i++) cap(i, i);
    rd(4'h0, d); check("R9 rd pend", d, 32'h0000_0301);
    check("R10 irq read", {31'b0, irq_o}, 32'h1);
    rd(4'hC, d);
    check("R10 irq drops", {31'b0, irq_o}, 32'h0);

    // R7 saturation
    for (int i = 0; i < 40; i++) cap(1000 + i, 2000 + i);
    rd(4'h4, d); check("R7 cap full", d, 32'h8080_8080);
    rd(4'h8, d); check("R7 oldest kept", d, 32'h0);

    // R8 capture clear
    wr(4'h0, 32'h5);
    rd(4'h0, d); check("R8 clr self", d, 32'h0000_0201);
    rd(4'h4, d); check("R8 cap clr", d, 32'h8080_0000);

    // R7 playback saturation, R9 write pending drops
    for (int i = 0; i < 130; i++) wr(4'h8, i);
    for (int i = 0; i < 130; i++) wr(4'hC, 500 + i);
    rd(4'h4, d); check("R7 ply full", d, 32'h0);
    wr(4'h0, 32'h2);
    rd(4'h0, d); check("R9 wr pend low", d, 32'h0000_0002);
    check("R10 irq low", {31'b0, irq_o}, 32'h0);
    check("R7 head", play_left_o, 32'h0);

    // R8 playback clear
    wr(4'h0, 32'hA);
    rd(4'h0, d); check("R8 ply clr ctrl", d, 32'h0000_0202);
    check("R10 irq up", {31'b0, irq_o}, 32'h1);
    rd(4'h4, d); check("R8 ply clr", d, 32'h8080_0000);
    check("R8 valid low", {31'b0, play_valid_o}, 32'h0);

    // R9 status bits read-only
    wr(4'h0, 32'h300);
    rd(4'h0, d); check("R9 ro", d, 32'h0000_0200);
    check("R9 irq", {31'b0, irq_o}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule